// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds two identical timer channels behind a small word-addressed register bus. Each channel has a control word, a reload value and a live counter. A channel counts one step per clock, either upward or downward. When it runs past its terminal value it raises a sticky event flag, and it then either reloads and keeps going or stops. This makes a channel useful as a periodic tick source, as a single-shot delay, or as a free-running time base that software can sample at any moment.

Software acknowledges a channel by writing its control word back with the flag bit set, since that bit clears on a one. A load bit parks the counter on the reload value until it is cleared again. A start-both bit in either control word switches both channels on in the same clock. The single interrupt line combines the flags of any channel whose interrupt is enabled. The bits for capture, external pins, pulse-width output and mode select are kept in the control word but have no effect on the hardware.

Top module: `twin_timer`

## Requirements
- R1: After reset, every register of both channels reads zero and `irq_o` is low.
- R2: Channel t sits at byte offset 16*t. Its control word is at +0x0, its reload value at +0x4 and its counter at +0x8. Offset +0xC, any address whose two low bits are not zero, and any channel index beyond the last channel read as zero and ignore writes. Writes to a counter are ignored. Control bits 10..0 read back as written, except bit 8, which shows the event flag. Bits above 10 read zero. The reload value reads back in its low CNT_W bits. Read data appears on `rdata_o` one clock after the cycle in which `rd_en_i` is high.
- R3: While control bit 5 (load) is 1, the counter takes the reload value on every clock and does not count, even when bit 7 is set. It follows changes to the reload value. Once bit 5 is 0, the counter keeps its value until counting starts.
- R4: With bit 1 = 1 (down), bit 4 = 1 (auto-reload) and bit 7 = 1 (run), the counter decrements each clock. One clock after it reads 0, it returns to the reload value L and the flag sets. The first flag appears L+1 clocks after the start write.
- R5: With bit 1 = 0, the counter increments each clock. At all-ones it rolls over to the reload value, so from a start at L the first flag appears 2^CNT_W − L clocks after the start write.
- R6: If bit 4 is 0 at a rollover, the flag sets, the counter holds at its terminal value, and bit 7 clears.
- R7: Writing 1 to bit 8 clears the flag. Writing 0 leaves it unchanged. Writing back the value just read clears the flag and leaves all mode bits as they were. A rollover in the same clock as a clear leaves the flag set.
- R8: `irq_o` is high exactly when some channel has both its flag and bit 6 (interrupt enable) set.
- R9: Clearing bit 7 freezes the counter at its current value. The other control bits and the flag keep their values.
- R10: A control write with bit 10 = 1, to either channel, sets bit 7 of both channels in that clock.
- R11: Bits 0, 2, 3 and 9 are stored but do not change counting, rollover timing or the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the word at `addr_i` |
| rd_en_i | input | 1 | Read strobe; data is returned on the next clock |
| addr_i | input | 4+clog2(NUM_TMR) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CNT_W = 8 and the default two channels. An 8-bit counter puts every rollover within a few hundred clocks. This lets the bench sweep all 256 reload values for down-counting and measure each period exactly against L+1. It also samples the up-counting reload range and compares it against 256 − L. The narrow counter also lets the one-shot stop, the acknowledge, the freeze and the start-both paths run to their terminal states within the cycle budget, so each is checked on both the register readback and the interrupt pin.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int BUS_W  = 32;
  localparam int CTRL_W = 11;

  localparam int B_MODE   = 0;
  localparam int B_DOWN   = 1;
  localparam int B_XGEN   = 2;
  localparam int B_XCAP   = 3;
  localparam int B_RELOAD = 4;
  localparam int B_LOAD   = 5;
  localparam int B_IE     = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;
  localparam int B_PWM    = 9;
  localparam int B_ALL    = 10;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/twin_timer_core.sv
module twin_timer_core
  import twin_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              load_we_i,
  input  logic              all_en_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  load_q, cnt_q, cnt_d;
  logic              counting, at_end, roll;

  always_comb begin
    counting = ctrl_q[B_RUN] && !ctrl_q[B_LOAD];
    at_end   = ctrl_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == CNT_TOP);
    roll     = counting && at_end;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (ctrl_q[B_LOAD]) begin
      cnt_d = load_q;
    end else if (roll) begin
      if (ctrl_q[B_RELOAD]) cnt_d = load_q;
    end else if (counting) begin
      cnt_d = ctrl_q[B_DOWN] ? (cnt_q - CNT_ONE) : (cnt_q + CNT_ONE);
    end
  end

  // software write wins over the one-shot stop; start-all and rollover flag win last
  always_comb begin
    ctrl_d = ctrl_q;
    if (roll && !ctrl_q[B_RELOAD]) ctrl_d[B_RUN] = 1'b0;
    if (ctrl_we_i) begin
      ctrl_d         = wdata_i[CTRL_W-1:0];
      ctrl_d[B_FLAG] = ctrl_q[B_FLAG] && !wdata_i[B_FLAG];
    end
    if (all_en_i) ctrl_d[B_RUN] = 1'b1;
    if (roll) ctrl_d[B_FLAG] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      if (load_we_i) load_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = ctrl_q[B_FLAG] && ctrl_q[B_IE];
endmodule

// File: rtl/twin_timer_bus.sv
module twin_timer_bus
  import twin_timer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [BUS_W-1:0]                wdata_i,
  input  logic [NUM_TMR-1:0][CTRL_W-1:0]  ctrl_i,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   load_i,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_i,
  output logic [NUM_TMR-1:0]              ctrl_we_o,
  output logic [NUM_TMR-1:0]              load_we_o,
  output logic                            all_en_o,
  output logic [BUS_W-1:0]                rdata_o
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;
  logic             aligned, idx_ok, hit;
  logic [BUS_W-1:0] rd_val, rdata_q;

  assign idx     = addr_i[ADDR_W-1:4];
  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign aligned = (addr_i[1:0] == 2'b00);

  generate
    if (NUM_TMR == (1 << IDX_W)) begin : g_full
      assign idx_ok = 1'b1;
    end else begin : g_part
      assign idx_ok = (int'(idx) < NUM_TMR);
    end
  endgenerate

  assign hit      = aligned && idx_ok;
  assign all_en_o = wr_en_i && hit && (sel == REG_CTRL) && wdata_i[B_ALL];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_we
    assign ctrl_we_o[t] = wr_en_i && hit && (sel == REG_CTRL) && (idx == IDX_W'(t));
    assign load_we_o[t] = wr_en_i && hit && (sel == REG_LOAD) && (idx == IDX_W'(t));
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      unique case (sel)
        REG_CTRL: rd_val[CTRL_W-1:0] = ctrl_i[idx];
        REG_LOAD: rd_val[CNT_W-1:0]  = load_i[idx];
        REG_CNT:  rd_val[CNT_W-1:0]  = cnt_i[idx];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int  NUM_TMR = 2,
  parameter int  CNT_W   = 32,
  localparam int ADDR_W  = 4 + $clog2(NUM_TMR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_w;
  logic [NUM_TMR-1:0][CNT_W-1:0]  load_w;
  logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_w;
  logic [NUM_TMR-1:0]             ctrl_we, load_we, irq_vec;
  logic                           all_en;

  twin_timer_bus #(
    .NUM_TMR(NUM_TMR),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) bus_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ctrl_i    (ctrl_w),
    .load_i    (load_w),
    .cnt_i     (cnt_w),
    .ctrl_we_o (ctrl_we),
    .load_we_o (load_we),
    .all_en_o  (all_en),
    .rdata_o   (rdata_o)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    twin_timer_core #(
      .CNT_W(CNT_W)
    ) core_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we[t]),
      .load_we_i (load_we[t]),
      .all_en_i  (all_en),
      .wdata_i   (wdata_i),
      .ctrl_o    (ctrl_w[t]),
      .load_o    (load_w[t]),
      .cnt_o     (cnt_w[t]),
      .irq_o     (irq_vec[t])
    );
  end

  assign irq_o = |irq_vec;
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int CNT_W   = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           irq_i,
  input logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  load_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_i
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic any_pending;
  always_comb begin
    any_pending = 1'b0;
    for (int t = 0; t < NUM_TMR; t++)
      if (ctrl_i[t][B_FLAG] && ctrl_i[t][B_IE]) any_pending = 1'b1;
  end

  // R8: a rising interrupt is backed by an enabled pending flag
  a_r8_irq_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> any_pending);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    logic live;
    assign live = ctrl_i[t][B_RUN] && !ctrl_i[t][B_LOAD];

    a_r3_load_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_i[t][B_LOAD] |=> (cnt_i[t] == $past(load_i[t])));

    a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_i[t][B_RUN] && !ctrl_i[t][B_LOAD]) |=> $stable(cnt_i[t]));

    a_r4_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && ctrl_i[t][B_DOWN] && cnt_i[t] != '0)
        |=> (cnt_i[t] == $past(cnt_i[t]) - CNT_ONE));

    a_r5_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && !ctrl_i[t][B_DOWN] && cnt_i[t] != CNT_TOP)
        |=> (cnt_i[t] == $past(cnt_i[t]) + CNT_ONE));

    a_r6_roll_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && (ctrl_i[t][B_DOWN] ? (cnt_i[t] == '0) : (cnt_i[t] == CNT_TOP)))
        |=> ctrl_i[t][B_FLAG]);
  end
endmodule

bind twin_timer twin_timer_chk #(
  .NUM_TMR(NUM_TMR),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_i  (irq_o),
  .ctrl_i (ctrl_w),
  .load_i (load_w),
  .cnt_i  (cnt_w)
);

// File: tb/twin_timer_tb_top.sv
module twin_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_timer #(.NUM_TMR(2), .CNT_W(CW)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // all tasks are entered and left at a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    logic [31:0] c1, c2;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd_chk("R1 ctrl0", 5'h00, 0);
    rd_chk("R1 load0", 5'h04, 0);
    rd_chk("R1 cnt0",  5'h08, 0);
    rd_chk("R1 ctrl1", 5'h10, 0);
    rd_chk("R1 load1", 5'h14, 0);
    rd_chk("R1 cnt1",  5'h18, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 map, readback, ignored writes; R11 bits stored
    wr(5'h00, 32'hFFFF_FA0D);
    rd_chk("R2 R11 ctrl readback", 5'h00, 32'h20D);
    rd_chk("R2 unaligned read", 5'h01, 0);
    wr(5'h08, 32'h77);
    rd_chk("R2 cnt0 write ignored", 5'h08, 0);
    wr(5'h18, 32'h77);
    rd_chk("R2 cnt1 write ignored", 5'h18, 0);
    wr(5'h14, 32'h1234_56AB);
    rd_chk("R2 load1 width", 5'h14, 32'hAB);
    wr(5'h05, 32'h33);
    rd_chk("R2 unaligned write ignored", 5'h04, 0);
    rd_chk("R2 hole 0x0C", 5'h0C, 0);
    rd_chk("R2 hole 0x1C", 5'h1C, 0);
    rd_chk("R2 ctrl1 untouched", 5'h10, 0);
    wr(5'h00, 32'h100);

    // R3 load strobe
    wr(5'h04, 32'h5A);
    wr(5'h00, 32'h020);
    idle(1);
    rd_chk("R3 load copy", 5'h08, 32'h5A);
    wr(5'h04, 32'h33);
    idle(1);
    rd_chk("R3 follows load", 5'h08, 32'h33);
    wr(5'h00, 32'h0A2);
    idle(3);
    rd_chk("R3 no count while load", 5'h08, 32'h33);
    wr(5'h00, 32'h000);
    idle(2);
    rd_chk("R3 holds after release", 5'h08, 32'h33);

    // R4 down periodic, all reload values; odd L adds inert bits (R11)
    for (int l = 0; l < 256; l++) begin
      wr(5'h00, 32'h100);
      wr(5'h00, 32'h100);
      wr(5'h04, 32'(l));
      wr(5'h00, 32'h020);
      wr(5'h00, 32'h1D2 | ((l % 2 == 1) ? 32'h20D : 32'h0));
      wait_irq(n);
      chk((l % 2 == 1) ? "R4 R11 down period" : "R4 down period", 32'(n), 32'(l + 1));
    end

    // R5 up counting rollover
    for (int l = 0; l < 256; l += 15) begin
      wr(5'h00, 32'h100);
      wr(5'h00, 32'h100);
      wr(5'h04, 32'(l));
      wr(5'h00, 32'h020);
      wr(5'h00, 32'h1D0);
      wait_irq(n);
      chk("R5 up rollover", 32'(n), 32'(256 - l));
    end

    // R6 one-shot
    wr(5'h00, 32'h100);
    wr(5'h00, 32'h100);
    wr(5'h04, 32'd5);
    wr(5'h00, 32'h020);
    wr(5'h00, 32'h1C2);
    wait_irq(n);
    chk("R6 one-shot delay", 32'(n), 32'd6);
    idle(3);
    rd_chk("R6 run cleared flag set", 5'h00, 32'h142);
    rd_chk("R6 counter holds 0", 5'h08, 0);

    // R7 write-one-to-clear
    wr(5'h00, 32'h042);
    rd_chk("R7 zero keeps flag", 5'h00, 32'h142);
    chk("R7 R8 irq still high", 32'(irq), 1);
    wr(5'h00, 32'h142);
    rd_chk("R7 writeback acks", 5'h00, 32'h042);
    chk("R7 R8 irq low after ack", 32'(irq), 0);

    // R8 free-running up counter, interrupt masked then unmasked
    wr(5'h14, 32'd250);
    wr(5'h10, 32'h020);
    wr(5'h10, 32'h190);
    idle(12);
    rd_chk("R8 R5 flag set masked", 5'h10, 32'h190);
    chk("R8 irq masked", 32'(irq), 0);
    wr(5'h10, 32'h0D0);
    chk("R8 irq on enable", 32'(irq), 1);

    // R9 freeze
    wr(5'h10, 32'h050);
    rd(5'h18, c1);
    idle(4);
    rd(5'h18, c2);
    chk("R9 counter frozen", c2, c1);
    rd_chk("R9 bits kept", 5'h10, 32'h150);

    // R10 start both from channel 1
    wr(5'h04, 32'd100);
    wr(5'h00, 32'h022);
    wr(5'h00, 32'h002);
    wr(5'h10, 32'h450);
    rd_chk("R10 ch0 run set", 5'h00, 32'h082);
    rd_chk("R10 ch0 counting", 5'h08, 32'd99);
    rd_chk("R10 ch1 run set", 5'h10, 32'h5D0);
    chk("R10 R8 irq", 32'(irq), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule